// File: doc/BRIEF.md
# Coprocessor Operand Interlock Stall Controller

This block sits between a host CPU and a floating-point coprocessor that has a single execution datapath. The host may fetch the operands of the next floating-point instruction while the current instruction is still executing. The controller collects those operand words in a small buffer. It keeps them away from the execution unit until the datapath is free. If the full operand set is ready while the datapath is still busy, it holds the host with a stall request.

When the execution unit drops its busy flag, the controller removes the stall and starts handing the buffered words to the execution unit at the same clock edge. Words go out one per cycle, in the order they arrived. The controller also decodes the direction of register transfer cycles from a 3-bit code, and it holds a floating-point exception flag for the host.

Operand words come in on a valid/ready stream. A word is taken on any rising edge where both `opnd_valid` and `opnd_ready` are high. While `opnd_ready` is low, the source must hold the word and `opnd_valid`. The release side has no back-pressure: the execution unit must take each `rel_valid` word in the cycle it is presented. The remaining pins are plain levels.

Top module: `coproc_interlock`

## Requirements
- R1: During reset and in the first cycle after it, `host_stall`, `rel_valid` and `exc_flag` are low, and the operand count is zero.
- R2: `opnd_ready` is high exactly when `next_pending` is high, fewer words than the instruction needs have been taken, and no release is in progress. A word is taken only when `opnd_valid` and `opnd_ready` are both high.
- R3: An instruction needs 2 words when `dbl_fmt` is 0 and 4 words when `dbl_fmt` is 1. The count is fixed when the first word of the instruction is taken.
- R4: `host_stall` rises in the cycle after the last needed word is taken while `exec_busy` is high. It then stays high for as long as `exec_busy` stays high.
- R5: `host_stall` falls in the cycle after a clock edge at which `exec_busy` is low. The first buffered word appears on `rel_valid`/`rel_data` in that same cycle.
- R6: No word is released while `exec_busy` was high at the edge that would start the release. A release presents every word in arrival order, one per cycle, in consecutive cycles.
- R7: If the operand set becomes complete while `exec_busy` is low, the words are released without any stall.
- R8: After the last word is released, the count returns to zero and a new instruction's words can be accepted.
- R9: With `xfer_valid` high, code 3'b011 drives `xfer_load` (transfer into the coprocessor) and code 3'b100 drives `xfer_store` (transfer out to a host register). Any other code, or `xfer_valid` low, drives neither.
- R10: `exc_flag` goes high in the cycle after an `exc_pulse`. It stays high until the edge that starts the next release, which clears it. If a pulse and a release start fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_busy | input | 1 | Execution unit is working on the current operation |
| next_pending | input | 1 | A following FP instruction is decoded and collecting operands |
| dbl_fmt | input | 1 | Format of the pending instruction: 0 single, 1 double |
| opnd_valid | input | 1 | Operand word valid |
| opnd_ready | output | 1 | Controller can take an operand word |
| opnd_data | input | 16 | Operand word |
| host_stall | output | 1 | Stall request to the host |
| rel_valid | output | 1 | One-cycle strobe per released operand word |
| rel_data | output | 16 | Released operand word |
| xfer_valid | input | 1 | Register transfer cycle in progress |
| xfer_code | input | 3 | Transfer direction code |
| xfer_load | output | 1 | Transfer toward the coprocessor |
| xfer_store | output | 1 | Transfer from the coprocessor to a host register |
| exc_pulse | input | 1 | Exception raised by the execution unit |
| exc_flag | output | 1 | Exception indication to the host |

## Verification
The bench first checks that the stall rises exactly one cycle after the final word while busy is high. A design that stalls on every prefetch, or one cycle late, fails that check. It also checks that the stall drop and the first release strobe land on the same cycle after busy falls. An off-by-one there would either let an operand reach a busy datapath or hold the host one cycle too long.

It also looks at the case where busy is already low when the last word arrives. A stall glitch there is a failure. It further watches for a format flag that changes mid-instruction, which would corrupt the word count. Across random streams with gaps in `opnd_valid`, release order and contiguity are checked, so a swapped buffer index or a dropped word shows up as a data mismatch.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  localparam int unsigned XCODE_W = 3;
  localparam logic [XCODE_W-1:0] XCODE_TO_COP   = 3'b011;
  localparam logic [XCODE_W-1:0] XCODE_FROM_COP = 3'b100;

  typedef enum logic [1:0] {
    XK_NONE  = 2'd0,
    XK_LOAD  = 2'd1,
    XK_STORE = 2'd2
  } xfer_kind_e;
endpackage

// File: rtl/ilk_opbuf.sv
module ilk_opbuf #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot [DEPTH];

  // one register per slot, written when the count points at it
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (wr_en && cnt == CNT_W'(g)) begin
        slot[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (wr_en) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign rd_data = slot[rd_idx];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cnt < CNT_W'(DEPTH)); // R2
endmodule

// File: rtl/ilk_stall_ctl.sv
module ilk_stall_ctl #(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned SGL_WORDS = 2,
  parameter int unsigned DBL_WORDS = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_busy,
  input  logic             next_pending,
  input  logic             dbl_fmt,
  input  logic             opnd_valid,
  input  logic [CNT_W-1:0] cnt,
  output logic             opnd_ready,
  output logic             wr_en,
  output logic             clr,
  output logic [IDX_W-1:0] rd_idx,
  output logic             draining,
  output logic             drain_start,
  output logic             stall
);
  logic [CNT_W-1:0] need_now, need_q, need_eff, cnt_inc;
  logic             full, last_arrive, last_rd, stall_d;

  assign need_now    = dbl_fmt ? CNT_W'(DBL_WORDS) : CNT_W'(SGL_WORDS);
  // the word count is frozen once the first word of an instruction is taken
  assign need_eff    = (cnt == '0) ? need_now : need_q;
  assign cnt_inc     = cnt + CNT_W'(1);
  assign full        = (cnt != '0) && (cnt == need_eff);

  assign opnd_ready  = next_pending && (cnt < need_eff) && !draining;
  assign wr_en       = opnd_valid && opnd_ready;
  assign last_arrive = wr_en && (cnt_inc == need_eff);
  assign drain_start = full && !exec_busy && !draining;
  assign last_rd     = draining && (CNT_W'(rd_idx) == need_q - CNT_W'(1));
  assign clr         = last_rd;
  assign stall_d     = exec_busy && !draining && (full || last_arrive);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      need_q <= CNT_W'(SGL_WORDS);
    end else if (wr_en && cnt == '0) begin
      need_q <= need_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      draining <= 1'b0;
      rd_idx   <= '0;
    end else if (drain_start) begin
      draining <= 1'b1;
      rd_idx   <= '0;
    end else if (last_rd) begin
      draining <= 1'b0;
      rd_idx   <= '0;
    end else if (draining) begin
      rd_idx   <= rd_idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stall <= 1'b0;
    else        stall <= stall_d;
  end

  AST_STALL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(exec_busy)); // R4
  AST_STALL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !exec_busy) |=> !stall); // R5
  AST_NO_RELEASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(draining) |-> !$past(exec_busy)); // R6
  AST_RELEASE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && !last_rd) |=> draining); // R6
  AST_NO_TAKE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    draining |-> !wr_en); // R2
endmodule

// File: rtl/ilk_xfer_dec.sv
module ilk_xfer_dec
  import ilk_pkg::*;
(
  input  logic               xfer_valid,
  input  logic [XCODE_W-1:0] xfer_code,
  output logic               xfer_load,
  output logic               xfer_store
);
  xfer_kind_e kind;

  always_comb begin
    kind = XK_NONE;
    if (xfer_valid) begin
      unique case (xfer_code)
        XCODE_TO_COP:   kind = XK_LOAD;
        XCODE_FROM_COP: kind = XK_STORE;
        default:        kind = XK_NONE;
      endcase
    end
  end

  assign xfer_load  = (kind == XK_LOAD);
  assign xfer_store = (kind == XK_STORE);

  always_comb begin
    AST_XFER_GATED: assert (xfer_valid || !(xfer_load || xfer_store)); // R9
  end
endmodule

// File: rtl/ilk_exc_hold.sv
module ilk_exc_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic exc_pulse,
  input  logic clear,
  output logic exc_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)         exc_flag <= 1'b0;
    else if (exc_pulse) exc_flag <= 1'b1;
    else if (clear)     exc_flag <= 1'b0;
  end

  AST_EXC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |=> exc_flag); // R10
endmodule

// File: rtl/coproc_interlock.sv
module coproc_interlock #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned SGL_WORDS = 2,
  parameter int unsigned DBL_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_busy,
  input  logic              next_pending,
  input  logic              dbl_fmt,
  input  logic              opnd_valid,
  output logic              opnd_ready,
  input  logic [DATA_W-1:0] opnd_data,
  output logic              host_stall,
  output logic              rel_valid,
  output logic [DATA_W-1:0] rel_data,
  input  logic              xfer_valid,
  input  logic [2:0]        xfer_code,
  output logic              xfer_load,
  output logic              xfer_store,
  input  logic              exc_pulse,
  output logic              exc_flag
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] rd_idx;
  logic             wr_en, clr, drain_start;

  ilk_opbuf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(opnd_data),
    .clr(clr), .rd_idx(rd_idx), .cnt(cnt), .rd_data(rel_data)
  );

  ilk_stall_ctl #(.DEPTH(DEPTH), .SGL_WORDS(SGL_WORDS), .DBL_WORDS(DBL_WORDS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .exec_busy(exec_busy), .next_pending(next_pending),
    .dbl_fmt(dbl_fmt), .opnd_valid(opnd_valid), .cnt(cnt), .opnd_ready(opnd_ready),
    .wr_en(wr_en), .clr(clr), .rd_idx(rd_idx), .draining(rel_valid),
    .drain_start(drain_start), .stall(host_stall)
  );

  ilk_xfer_dec u_xfer (
    .xfer_valid(xfer_valid), .xfer_code(xfer_code),
    .xfer_load(xfer_load), .xfer_store(xfer_store)
  );

  ilk_exc_hold u_exc (
    .clk(clk), .rst_n(rst_n), .exc_pulse(exc_pulse),
    .clear(drain_start), .exc_flag(exc_flag)
  );

  initial begin
    AST_PARAM_ORDER: assert (SGL_WORDS >= 1 && SGL_WORDS <= DBL_WORDS && DBL_WORDS <= DEPTH); // R3
  end
endmodule

// File: tb/sim_coproc_interlock.sv
`timescale 1ns/1ps
module sim_coproc_interlock;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exec_busy = 0, next_pending = 0, dbl_fmt = 0, opnd_valid = 0;
  logic [15:0] opnd_data = '0;
  logic xfer_valid = 0, exc_pulse = 0;
  logic [2:0] xfer_code = '0;
  logic opnd_ready, host_stall, rel_valid, xfer_load, xfer_store, exc_flag;
  logic [15:0] rel_data;

  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  coproc_interlock u0 (
    .clk(clk), .rst_n(rst_n), .exec_busy(exec_busy), .next_pending(next_pending),
    .dbl_fmt(dbl_fmt), .opnd_valid(opnd_valid), .opnd_ready(opnd_ready),
    .opnd_data(opnd_data), .host_stall(host_stall), .rel_valid(rel_valid),
    .rel_data(rel_data), .xfer_valid(xfer_valid), .xfer_code(xfer_code),
    .xfer_load(xfer_load), .xfer_store(xfer_store), .exc_pulse(exc_pulse),
    .exc_flag(exc_flag)
  );

  // reference state, written from the requirements
  int m_cnt = 0, m_need = 2, m_rd = 0;
  logic m_drain = 0, m_stall = 0, m_exc = 0;
  logic [15:0] m_buf [4];

  function automatic int need_of(logic d);          // R3
    return d ? 4 : 2;
  endfunction
  function automatic int eff_need();
    return (m_cnt == 0) ? need_of(dbl_fmt) : m_need;
  endfunction
  function automatic logic exp_ready();             // R2
    return next_pending && (m_cnt < eff_need()) && !m_drain;
  endfunction
  function automatic logic exp_load();              // R9
    return xfer_valid && xfer_code == 3'b011;
  endfunction
  function automatic logic exp_store();             // R9
    return xfer_valid && xfer_code == 3'b100;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_drain = 0; m_rd = 0; m_stall = 0; m_exc = 0; m_need = 2;
    end else begin
      logic acc, full, start, last;
      int ne;
      ne    = eff_need();
      acc   = exp_ready() && opnd_valid;
      full  = (m_cnt != 0) && (m_cnt == ne);
      start = full && !exec_busy && !m_drain;
      m_stall = exec_busy && !m_drain && (full || (acc && m_cnt + 1 == ne));
      last  = m_drain && (m_rd == m_need - 1);
      if (acc) begin
        m_buf[m_cnt] = opnd_data;
        if (m_cnt == 0) m_need = ne;
        m_cnt++;
      end
      if (start) begin
        m_drain = 1; m_rd = 0;
      end else if (last) begin
        m_drain = 0; m_rd = 0; m_cnt = 0;
      end else if (m_drain) m_rd++;
      if (exc_pulse) m_exc = 1;
      else if (start) m_exc = 0;
    end
  end

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    cmp("R2 opnd_ready", 16'(opnd_ready), 16'(exp_ready()));
    cmp("R4/R5/R7 host_stall", 16'(host_stall), 16'(m_stall));
    cmp("R6/R8 rel_valid", 16'(rel_valid), 16'(m_drain));
    if (m_drain) cmp("R6 rel_data order", rel_data, m_buf[m_rd]);
    cmp("R9 xfer_load", 16'(xfer_load), 16'(exp_load()));
    cmp("R9 xfer_store", 16'(xfer_store), 16'(exp_store()));
    cmp("R10 exc_flag", 16'(exc_flag), 16'(m_exc));
  endtask

  task automatic cyc(input logic b, input logic p, input logic d, input logic v,
                     input logic [15:0] dat, input logic xv, input logic [2:0] xc,
                     input logic e);
    @(negedge clk);
    check_all();  // state after the last edge, previous inputs
    exec_busy = b; next_pending = p; dbl_fmt = d; opnd_valid = v;
    opnd_data = dat; xfer_valid = xv; xfer_code = xc; exc_pulse = e;
    #1;
    check_all();
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic b, dd;
    repeat (3) @(negedge clk);
    // R1: reset values
    cmp("R1 stall in reset", 16'(host_stall), 16'd0);
    cmp("R1 rel_valid in reset", 16'(rel_valid), 16'd0);
    cmp("R1 exc_flag in reset", 16'(exc_flag), 16'd0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 16'h0, 0, 3'd0, 0);
    cmp("R1 stall after reset", 16'(host_stall), 16'd0);

    // R4/R5/R6: single format while busy; stall then joint release
    cyc(1, 1, 0, 1, 16'hA001, 0, 3'd0, 0);
    cyc(1, 1, 0, 1, 16'hA002, 0, 3'd0, 0);
    cyc(1, 1, 0, 1, 16'hDEAD, 0, 3'd0, 0);  // R2 refused: buffer holds its 2 words
    cmp("R4 stall after last word", 16'(host_stall), 16'd1);
    cyc(1, 1, 0, 0, 16'h0, 0, 3'd0, 1);     // R10 exception while stalled
    cyc(0, 1, 0, 0, 16'h0, 0, 3'd0, 0);     // busy falls
    cyc(0, 1, 0, 0, 16'h0, 0, 3'd0, 0);
    cmp("R5 stall dropped", 16'(host_stall), 16'd0);
    cmp("R5 first word out", rel_data, 16'hA001);
    cyc(0, 1, 0, 0, 16'h0, 0, 3'd0, 0);
    cmp("R6 second word out", rel_data, 16'hA002);
    cyc(0, 1, 0, 0, 16'h0, 0, 3'd0, 0);
    cmp("R8 release done", 16'(rel_valid), 16'd0);
    cmp("R8 ready again", 16'(opnd_ready), 16'd1);

    // R7: double format with busy low, no stall
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 1, 16'hB000 + 16'(i), 0, 3'd0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, 0, 16'h0, 0, 3'd0, 0);
    // R3: format flag flips after first word; count stays at 4
    cyc(1, 1, 1, 1, 16'hC000, 0, 3'd0, 0);
    for (int i = 1; i < 4; i++) cyc(1, 1, 0, 1, 16'hC000 + 16'(i), 0, 3'd0, 0);
    cyc(1, 1, 0, 0, 16'h0, 0, 3'd0, 0);
    cmp("R3 stall after 4th word", 16'(host_stall), 16'd1);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 16'h0, 0, 3'd0, 0);
    // R9: every transfer code with and without valid
    for (int c = 0; c < 8; c++) begin
      cyc(0, 0, 0, 0, 16'h0, 1, 3'(c), 0);
      cyc(0, 0, 0, 0, 16'h0, 0, 3'(c), 0);
    end

    // random phase, fixed seed
    void'($urandom(32'h5EED_1234));
    b = 0; dd = 0;
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(5) == 0) b = ~b;
      if (m_cnt == 0 && !m_drain && $urandom_range(3) == 0) dd = ~dd;
      cyc(b, $urandom_range(7) != 0, dd, $urandom_range(1) == 1, 16'($urandom),
          $urandom_range(1) == 1, 3'($urandom), $urandom_range(19) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule